// File: doc/BRIEF.md
# Dual-Word NCO Phase Accumulator

This block is the phase engine of a direct digital synthesizer. Each sample clock it advances a wide phase accumulator by a step made of two frequency words: a center word and an offset word. A single enable pin decides whether the offset word takes part in the step. Toggling that pin moves the output between two frequencies within a few cycles, which is how frequency-shift keying is done. Both words come from a register bank outside this block and arrive here as plain inputs.

A 2-bit phase-select pin rotates the output by a whole quadrant, which supports phase-shift keying. The rotation is added into the top two bits of the output word only, so the accumulated phase is never disturbed. The output is the upper slice of the rotated phase and is meant to address a later sine lookup.

The sum of the two words is registered before it reaches the accumulator, so no single cycle holds two wide adds in series.

Top module: `nco_phase_core`

## Requirements
- R1: A synchronous active-low reset (`rstN` low at a rising clock edge) clears both the accumulator and the registered step to zero. While the accumulator is zero, `phaseOut` equals the quadrant offset alone.
- R2: With `offsetEn` high, the step is `centerWord + offsetWord` modulo 2^ACC_W.
- R3: With `offsetEn` low, zero replaces the offset word in the step. Raising `offsetEn` again restores the full step with the unchanged `offsetWord`.
- R4: The accumulator wraps modulo 2^ACC_W, and no flag or saturation occurs.
- R5: The phase-select code adds 0, 1/4, 1/2 or 3/4 of a cycle for the codes 00, 01, 10 and 11. It does this by adding the code into the two most significant bits of `phaseOut`, and it never alters the accumulator state.
- R6: `phaseSel` and `offsetEn` act without waiting for any strobe. `phaseSel` changes `phaseOut` in the same cycle it changes.
- R7: `phaseOut` is the top OUT_W bits of the accumulator, plus the quadrant offset, taken modulo 2^OUT_W.
- R8: Frequency inputs sampled at edge k are registered as the step at edge k. The step is added into the accumulator at edge k+1, so the added latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; state advances on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| centerWord | input | ACC_W | Center frequency word |
| offsetWord | input | ACC_W | Offset frequency word |
| offsetEn | input | 1 | High: offset word joins the step; low: zero is used |
| phaseSel | input | 2 | Quadrant phase rotation code |
| phaseOut | output | OUT_W | Truncated, rotated phase word |

## Verification
The bench builds the block with ACC_W = 20 and OUT_W = 10, in place of the default 48 and 16. With these narrower words the accumulator wraps within a handful of cycles when the steps are large. The wrap of the output slice and the carry into the quadrant bits can therefore be seen directly. A narrow width also keeps the reference model's arithmetic exact in 64-bit integers. The bench compares against that model on every cycle while it switches the offset enable, cycles through all four quadrant codes and changes the words in single steps to expose the one-cycle latency.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic       clear;
    logic       gateOffset;
    logic [1:0] quadrant;
  } nco_strobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic        rstN,
  input  logic        offsetEn,
  input  logic [1:0]  phaseSel,
  output nco_strobe_t strobes
);
  // Pins act directly: no staging, no transfer strobe.
  always_comb begin
    strobes.clear      = !rstN;
    strobes.gateOffset = offsetEn;
    strobes.quadrant   = phaseSel;
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  nco_strobe_t       strobes,
  input  logic [ACC_W-1:0]  centerWord,
  input  logic [ACC_W-1:0]  offsetWord,
  output logic [ACC_W-1:0]  accState,
  output logic [ACC_W-1:0]  stepState,
  output logic [OUT_W-1:0]  phaseOut
);
  localparam int PAD_W = OUT_W - 2;

  logic [ACC_W-1:0] gatedOffset;
  logic [ACC_W-1:0] stepQ;
  logic [ACC_W-1:0] accQ;
  logic [OUT_W-1:0] accTop;

  assign gatedOffset = strobes.gateOffset ? offsetWord : '0;

  // Stage 1: register the word sum; stage 2: accumulate.
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      stepQ <= '0;
      accQ  <= '0;
    end else begin
      stepQ <= centerWord + gatedOffset;
      accQ  <= accQ + stepQ;
    end
  end

  assign accTop = accQ[ACC_W-1 -: OUT_W];

  generate
    if (PAD_W > 0) begin : g_wide
      assign phaseOut = accTop + {strobes.quadrant, {PAD_W{1'b0}}};
    end else begin : g_narrow
      assign phaseOut = accTop + strobes.quadrant;
    end
  endgenerate

  assign accState  = accQ;
  assign stepState = stepQ;
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] centerWord,
  input  logic [ACC_W-1:0] offsetWord,
  input  logic             offsetEn,
  input  logic [1:0]       phaseSel,
  output logic [OUT_W-1:0] phaseOut
);
  nco_strobe_t      strobes;
  logic [ACC_W-1:0] accState;
  logic [ACC_W-1:0] stepState;

  nco_ctrl u_ctrl (
    .rstN     (rstN),
    .offsetEn (offsetEn),
    .phaseSel (phaseSel),
    .strobes  (strobes)
  );

  nco_datapath #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .centerWord (centerWord),
    .offsetWord (offsetWord),
    .accState   (accState),
    .stepState  (stepState),
    .phaseOut   (phaseOut)
  );
endmodule

// File: rtl/nco_phase_chk.sv
module nco_phase_chk #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [ACC_W-1:0] centerWord,
  input logic [ACC_W-1:0] offsetWord,
  input logic             offsetEn,
  input logic [1:0]       phaseSel,
  input logic [OUT_W-1:0] phaseOut,
  input logic [ACC_W-1:0] accState,
  input logic [ACC_W-1:0] stepState
);
  logic [ACC_W-1:0] wantStep;
  logic [OUT_W-1:0] rotation;
  logic [OUT_W-1:0] accTop;
  logic             resetSeen;

  assign wantStep = centerWord + (offsetEn ? offsetWord : {ACC_W{1'b0}});
  assign rotation = OUT_W'(phaseSel) << (OUT_W - 2);
  assign accTop   = accState[ACC_W-1 -: OUT_W];

  always_ff @(posedge clk) resetSeen <= !rstN;

  always @(negedge clk) begin
    if (resetSeen === 1'b1) begin
      AST_RESET_CLEAR: assert (accState == '0 && stepState == '0); // R1
    end
  end

  AST_STEP_SUM: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> stepState == $past(wantStep)); // R2

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> accState == ACC_W'($past(accState) + $past(stepState))); // R8

  AST_QUADRANT: assert property (@(posedge clk) disable iff (!rstN)
    OUT_W'(phaseOut - accTop) == rotation); // R5
endmodule

bind nco_phase_core nco_phase_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .centerWord (centerWord),
  .offsetWord (offsetWord),
  .offsetEn   (offsetEn),
  .phaseSel   (phaseSel),
  .phaseOut   (phaseOut),
  .accState   (accState),
  .stepState  (stepState)
);

// File: tb/test_nco_phase_core.sv
module test_nco_phase_core;
  localparam int ACC_W = 20;
  localparam int OUT_W = 10;
  localparam longint ACC_MOD = 64'd1 << ACC_W;
  localparam longint OUT_MOD = 64'd1 << OUT_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [ACC_W-1:0] centerWord = '0;
  logic [ACC_W-1:0] offsetWord = '0;
  logic             offsetEn = 1'b0;
  logic [1:0]       phaseSel = 2'd0;
  logic [OUT_W-1:0] phaseOut;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  longint mdlAcc = 0;
  longint mdlStep[$];

  always #10 clk = ~clk;

  nco_phase_core #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_nco_phase_core (
    .clk        (clk),
    .rstN       (rstN),
    .centerWord (centerWord),
    .offsetWord (offsetWord),
    .offsetEn   (offsetEn),
    .phaseSel   (phaseSel),
    .phaseOut   (phaseOut)
  );

  // Behavioural reference: a queue carries the one-cycle step latency.
  initial mdlStep.push_back(0);
  always @(posedge clk) begin
    if (!rstN) begin
      mdlAcc = 0;
      mdlStep.delete();
      mdlStep.push_back(0);
    end else begin
      mdlAcc = (mdlAcc + mdlStep.pop_front()) % ACC_MOD;
      mdlStep.push_back((longint'(centerWord) +
                         (offsetEn ? longint'(offsetWord) : 0)) % ACC_MOD);
    end
  end

  function automatic longint expectPhase();
    longint top = mdlAcc >> (ACC_W - OUT_W);
    return (top + (longint'(phaseSel) << (OUT_W - 2))) % OUT_MOD;
  endfunction

  task automatic compare();
    longint want = expectPhase();
    checks++;
    if (longint'(phaseOut) != want) begin
      errors++;
      $display("FAIL %s: phaseOut actual %0d expected %0d", curTag, phaseOut, want);
    end
  endtask

  // One cycle: check on the falling edge, then apply the next inputs.
  task automatic cycle(input logic [ACC_W-1:0] c, input logic [ACC_W-1:0] o,
                       input logic en, input logic [1:0] q);
    @(negedge clk);
    compare();
    centerWord = c;
    offsetWord = o;
    offsetEn   = en;
    phaseSel   = q;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, quadrant visible on an otherwise zero phase
    curTag = "R1";
    phaseSel = 2'd2;
    centerWord = 20'h12345;
    repeat (3) cycle(20'h12345, 20'h00777, 1'b1, 2'd2);
    rstN = 1'b1;
    // R8: single step change reveals one-cycle latency
    curTag = "R8";
    cycle(20'h00400, 20'h00000, 1'b0, 2'd0);
    repeat (4) cycle(20'h00000, 20'h00000, 1'b0, 2'd0);
    cycle(20'h01000, 20'h00000, 1'b0, 2'd0);
    repeat (3) cycle(20'h01000, 20'h00000, 1'b0, 2'd0);
    // R2: center plus offset
    curTag = "R2";
    repeat (20) cycle(20'h03210, 20'h00F00, 1'b1, 2'd0);
    // R3: offset gated off, then restored with the unchanged word
    curTag = "R3";
    repeat (15) cycle(20'h03210, 20'h00F00, 1'b0, 2'd0);
    repeat (10) cycle(20'h03210, 20'h00F00, 1'b1, 2'd0);
    repeat (6)  cycle(20'h03210, 20'h00F00, 1'b0, 2'd0);
    // R6: enable toggled every cycle takes effect without a strobe
    curTag = "R6";
    for (int i = 0; i < 12; i++) cycle(20'h01111, 20'h0A000, 1'(i % 2), 2'(i % 4));
    // R5: each quadrant code, state untouched by rotation changes
    curTag = "R5";
    for (int i = 0; i < 16; i++) cycle(20'h00321, 20'h00000, 1'b0, 2'(i));
    // R4: large steps force frequent wraps, including carry from both words
    curTag = "R4";
    repeat (25) cycle(20'hFFFF0, 20'h0F00F, 1'b1, 2'd1);
    repeat (25) cycle(20'h7FFFF, 20'h80003, 1'b1, 2'd3);
    // R7: step just below one output LSB shows truncation of low bits
    curTag = "R7";
    repeat (20) cycle(20'h003FF, 20'h00000, 1'b0, 2'd0);
    repeat (10) cycle(20'h00401, 20'h00000, 1'b0, 2'd2);
    // R1: reset again mid-run
    curTag = "R1";
    rstN = 1'b0;
    repeat (3) cycle(20'h55555, 20'h11111, 1'b1, 2'd3);
    rstN = 1'b1;
    curTag = "R2";
    repeat (10) cycle(20'h00ABC, 20'h00123, 1'b1, 2'd1);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule